// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Engine with Residue Check

This block folds one byte per clock into a 16-bit cyclic redundancy check built on the generator x^16 + x^12 + x^5 + 1. A sender pulses the start strobe at the head of a frame, streams the payload bytes, and then takes the inverted remainder from the CRC output and appends it to the frame, upper byte first. A receiver pulses start in the same way and streams both the payload and the two received checksum bytes. One clock after the last checksum byte, the check-OK flag shows whether the register ended on the fixed good-frame residue.

A parameter picks how the bits inside each byte enter the register. In the default order the most significant bit enters first. The alternative processes bit 0 first on a mirrored register. The residue constant and the byte order of the CRC output follow that choice, so in both orders the upper byte of the CRC output is the first checksum byte on the wire.

The byte input is a valid/ready stream. The engine never applies back-pressure: ready is low only while reset is asserted and is held high from the first clock edge after reset is released. A byte is taken on every rising edge where both valid and ready are high. Start and check-OK are plain control and status pins.

Top module: `crc16_engine`

## Requirements
- R1: While reset is asserted and after it is released, the register holds 0xFFFF. Therefore crc_o reads 0x0000, chk_ok_o is 0 and in_ready_o is 0 until the first edge after release.
- R2: From the first rising edge after reset release, in_ready_o stays 1. The engine never stalls a byte.
- R3: A start pulse with no byte reloads the register to 0xFFFF, so crc_o reads 0x0000 on the next cycle. If a byte is accepted in the same cycle as start, that byte is folded into 0xFFFF and not into the old value.
- R4: With LSB_FIRST=0, each accepted byte advances the register by eight serial steps, bit 7 first. Each step shifts left and XORs in 0x1021 whenever the outgoing bit 15 differs from the data bit.
- R5: With LSB_FIRST=1, each accepted byte advances the register by eight serial steps, bit 0 first. Each step shifts right and XORs in 0x8408 whenever the outgoing bit 0 differs from the data bit.
- R6: In a cycle with neither an accepted byte nor start, the register and chk_ok_o keep their values.
- R7: crc_o is the bitwise inverse of the register. With LSB_FIRST=1 its two bytes are swapped so that crc_o[15:8] is always sent first. For the ASCII bytes "123456789", crc_o reads 0xD64E with LSB_FIRST=0 and 0x6E90 with LSB_FIRST=1.
- R8: chk_ok_o is registered and is updated only on an accepted byte. It goes to 1 exactly when that byte leaves the register at 0x1D0F (LSB_FIRST=0) or 0xF0B8 (LSB_FIRST=1). A start pulse with no byte clears it.
- R9: A frame whose appended checksum has any single bit flipped leaves chk_ok_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start: preset the register to all ones |
| in_valid_i | input | 1 | Byte stream valid |
| in_ready_o | output | 1 | Byte stream ready (high whenever out of reset) |
| in_data_i | input | 8 | Byte to fold into the register |
| crc_o | output | 16 | Checksum to append, upper byte first |
| chk_ok_o | output | 1 | Registered good-residue flag |

## Verification
The nine-byte ASCII digit string is run in both bit orders and matched against its published checksums. This catches a wrong polynomial, a wrong preset or a wrong output inversion, which a self-consistent model would miss. Frames with their own correct checksum appended must raise the check flag, while the same frames with one checksum bit flipped must not. Together these separate a correct residue constant from one that matches too often. Payloads with idle gaps, a start arriving together with its first byte, and a restart mid-frame without data show the difference between holding, presetting and folding into the preset.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;

  typedef logic [CRC_W-1:0]  crc_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Good-frame residues for the CCITT generator, one per bit order
  localparam crc_t RESIDUE_MSB = 16'h1D0F;
  localparam crc_t RESIDUE_LSB = 16'hF0B8;

  function automatic crc_t mirror(input crc_t v);
    crc_t r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc16_byte_step.sv
// One byte of next-state logic: eight unrolled serial steps, flattened into an XOR network.
module crc16_byte_step
  import crc16_pkg::*;
#(
  parameter crc_t POLY    = 16'h1021,
  parameter bit   REFLECT = 1'b0
) (
  input  crc_t  crc_i,
  input  byte_t byte_i,
  output crc_t  crc_o
);
  localparam crc_t RPOLY = mirror(POLY);

  logic [BYTE_W:0][CRC_W-1:0] chain;
  assign chain[0] = crc_i;

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    if (REFLECT) begin : g_lsb
      logic fb;
      assign fb         = chain[b][0] ^ byte_i[b];
      assign chain[b+1] = (chain[b] >> 1) ^ ({CRC_W{fb}} & RPOLY);
    end else begin : g_msb
      logic fb;
      assign fb         = chain[b][CRC_W-1] ^ byte_i[BYTE_W-1-b];
      assign chain[b+1] = (chain[b] << 1) ^ ({CRC_W{fb}} & POLY);
    end
  end

  assign crc_o = chain[BYTE_W];
endmodule

// File: rtl/crc16_out_fmt.sv
// Inverts the register and orders the bytes so that the upper output byte is transmitted first.
module crc16_out_fmt
  import crc16_pkg::*;
#(
  parameter bit REFLECT = 1'b0
) (
  input  crc_t state_i,
  output crc_t crc_o
);
  crc_t inv;
  assign inv = ~state_i;

  if (REFLECT) begin : g_swap
    assign crc_o = {inv[BYTE_W-1:0], inv[CRC_W-1:BYTE_W]};
  end else begin : g_keep
    assign crc_o = inv;
  end
endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crc16_pkg::*;
#(
  parameter logic [15:0] POLY      = 16'h1021,
  parameter bit          LSB_FIRST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  output logic [15:0] crc_o,
  output logic        chk_ok_o
);
  localparam crc_t PRESET  = '1;
  localparam crc_t RESIDUE = LSB_FIRST ? RESIDUE_LSB : RESIDUE_MSB;

  crc_t state_q, base, next;
  logic ready_q, ok_q, accept;

  assign accept = in_valid_i && ready_q;
  // A start in the same cycle as a byte folds that byte into the preset
  assign base   = start_i ? PRESET : state_q;

  crc16_byte_step #(.POLY(POLY), .REFLECT(LSB_FIRST)) u_step (
    .crc_i (base),
    .byte_i(in_data_i),
    .crc_o (next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PRESET;
      ready_q <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      ready_q <= 1'b1;
      if (accept) begin
        state_q <= next;
        ok_q    <= (next == RESIDUE);
      end else if (start_i) begin
        state_q <= PRESET;
        ok_q    <= 1'b0;
      end
    end
  end

  crc16_out_fmt #(.REFLECT(LSB_FIRST)) u_fmt (
    .state_i(state_q),
    .crc_o  (crc_o)
  );

  assign in_ready_o = ready_q;
  assign chk_ok_o   = ok_q;
endmodule

// File: rtl/crc16_engine_chk.sv
module crc16_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic [7:0]  in_data_i,
  input logic [15:0] crc_o,
  input logic        chk_ok_o
);
  a_r2_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready_o);

  a_r3_start_presets: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !in_valid_i) |=> (crc_o == 16'h0000));

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !in_valid_i) |=> ($stable(crc_o) && $stable(chk_ok_o)));

  a_r8_start_clears_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !in_valid_i) |=> !chk_ok_o);

  a_r8_ok_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chk_ok_o) |-> $past(in_valid_i && in_ready_o));

  logic unused_data;
  assign unused_data = ^in_data_i;
endmodule

bind crc16_engine crc16_engine_chk u_chk (.*);

// File: tb/crc16_engine_bench.sv
module crc16_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       stt [2];
  logic       vl  [2];
  logic [7:0] dt  [2];
  logic       rdy [2];
  logic [15:0] crc [2];
  logic       ok  [2];

  crc16_engine #(.LSB_FIRST(1'b0)) u_crc16_engine (
    .clk(clk), .rst_n(rst_n), .start_i(stt[0]), .in_valid_i(vl[0]),
    .in_ready_o(rdy[0]), .in_data_i(dt[0]), .crc_o(crc[0]), .chk_ok_o(ok[0]));

  crc16_engine #(.LSB_FIRST(1'b1)) u_crc16_engine_refl (
    .clk(clk), .rst_n(rst_n), .start_i(stt[1]), .in_valid_i(vl[1]),
    .in_ready_o(rdy[1]), .in_data_i(dt[1]), .crc_o(crc[1]), .chk_ok_o(ok[1]));

  int checks = 0;
  int fails  = 0;

  // Behavioural reference: bit-at-a-time register per mode
  int unsigned ms  [2];
  bit          mok [2];
  bit          mrdy[2];

  function automatic int unsigned serial_byte(int m, int unsigned s, int unsigned d);
    int unsigned r = s;
    for (int k = 0; k < 8; k++) begin
      if (m == 0) begin
        int unsigned bitin = (d >> (7 - k)) & 1;
        int unsigned top   = (r >> 15) & 1;
        r = (r << 1) & 32'hFFFF;
        if ((top ^ bitin) != 0) r = r ^ 32'h1021;
      end else begin
        int unsigned bitin = (d >> k) & 1;
        int unsigned low   = r & 1;
        r = r >> 1;
        if ((low ^ bitin) != 0) r = r ^ 32'h8408;
      end
    end
    return r;
  endfunction

  function automatic logic [15:0] model_out(int m);
    logic [15:0] inv = ~ms[m][15:0];
    return (m == 0) ? inv : {inv[7:0], inv[15:8]};
  endfunction

  task automatic check(bit cond, string req, int unsigned act, int unsigned exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    for (int m = 0; m < 2; m++) begin
      if (!rst_n) begin
        ms[m] = 32'hFFFF; mok[m] = 1'b0; mrdy[m] = 1'b0;
      end else begin
        if (vl[m] && mrdy[m]) begin
          ms[m]  = serial_byte(m, stt[m] ? 32'hFFFF : ms[m], dt[m]);
          mok[m] = (ms[m] == ((m == 0) ? 32'h1D0F : 32'hF0B8));
        end else if (stt[m]) begin
          ms[m] = 32'hFFFF; mok[m] = 1'b0;
        end
        mrdy[m] = 1'b1;
      end
    end
  endtask

  task automatic compare_all();
    for (int m = 0; m < 2; m++) begin
      check(crc[m] == model_out(m), (m == 0) ? "R4 crc msb-first" : "R5 crc lsb-first",
            crc[m], model_out(m));
      check(ok[m] == mok[m], "R8 chk_ok", ok[m], mok[m]);
      check(rdy[m] == mrdy[m], "R2 ready", rdy[m], mrdy[m]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic send(int m, logic [7:0] d, bit st);
    vl[m] = 1'b1; dt[m] = d; stt[m] = st;
    tick();
    vl[m] = 1'b0; stt[m] = 1'b0;
  endtask

  task automatic pulse_start(int m);
    stt[m] = 1'b1;
    tick();
    stt[m] = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] cs;
    for (int m = 0; m < 2; m++) begin
      stt[m] = 0; vl[m] = 0; dt[m] = 0;
      ms[m] = 32'hFFFF; mok[m] = 0; mrdy[m] = 0;
    end
    repeat (3) tick();
    // R1: reset state
    for (int m = 0; m < 2; m++) begin
      check(crc[m] == 16'h0000, "R1 crc in reset", crc[m], 16'h0000);
      check(ok[m] == 1'b0, "R1 chk_ok in reset", ok[m], 0);
      check(rdy[m] == 1'b0, "R1 ready in reset", rdy[m], 0);
    end
    @(negedge clk); rst_n = 1'b1;
    tick();
    for (int m = 0; m < 2; m++) check(rdy[m] == 1'b1, "R2 ready after reset", rdy[m], 1);

    // R7: known vectors on the digit string, start folded with the first byte (R3)
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 9; i++) send(m, 8'h31 + 8'(i), i == 0);
      check(crc[m] == ((m == 0) ? 16'hD64E : 16'h6E90), "R7 known vector",
            crc[m], (m == 0) ? 16'hD64E : 16'h6E90);
      cs = crc[m];
      send(m, cs[15:8], 1'b0);
      check(ok[m] == 1'b0, "R8 ok low mid checksum", ok[m], 0);
      send(m, cs[7:0], 1'b0);
      check(ok[m] == 1'b1, "R8 good frame residue", ok[m], 1);
    end

    // R6: idle cycles hold the value and the flag
    for (int m = 0; m < 2; m++) begin
      cs = crc[m];
      repeat (4) tick();
      check(crc[m] == cs, "R6 hold across idle", crc[m], cs);
      check(ok[m] == 1'b1, "R6 flag held across idle", ok[m], 1);
    end

    // R3 / R8: start without data presets and clears the flag
    for (int m = 0; m < 2; m++) begin
      pulse_start(m);
      check(crc[m] == 16'h0000, "R3 start presets", crc[m], 16'h0000);
      check(ok[m] == 1'b0, "R8 start clears flag", ok[m], 0);
    end

    // Gapped payloads, good checksum then flipped checksum bits (R9)
    for (int m = 0; m < 2; m++) begin
      for (int trial = 0; trial < 6; trial++) begin
        int len = 3 + trial * 5;
        pulse_start(m);
        for (int i = 0; i < len; i++) begin
          send(m, 8'((i * 37 + trial * 101 + m * 13) ^ (i << 3)), 1'b0);
          if ((i % 4) == 2) tick();
        end
        cs = model_out(m);
        if (trial % 2 == 1) cs = cs ^ (16'h0001 << trial);
        send(m, cs[15:8], 1'b0);
        tick();
        send(m, cs[7:0], 1'b0);
        if (trial % 2 == 1)
          check(ok[m] == 1'b0, "R9 corrupted checksum rejected", ok[m], 0);
        else
          check(ok[m] == 1'b1, "R8 gapped good frame", ok[m], 1);
      end
    end

    // R3: start with a byte mid-frame restarts from the preset
    for (int m = 0; m < 2; m++) begin
      send(m, 8'hA5, 1'b0);
      send(m, 8'h3C, 1'b1);
      check(crc[m] == model_out(m), "R3 start with byte", crc[m], model_out(m));
    end

    summary();
    $finish;
  end
endmodule